// File: doc/BRIEF.md
# Hamming(7,4) Single-Error-Correcting Codec with Runtime Parity Sense

This block protects a 4-bit nibble with three check bits, so that any single flipped bit in the 7-bit word can be corrected. It has two independent paths. The encode path takes a nibble and returns a 7-bit codeword. The check path takes a received 7-bit word and returns the syndrome, an error flag, the repaired word and the recovered nibble.

Each path has its own parity-sense input, which selects even or odd check bits at run time. A word must be checked in the same sense in which it was encoded. Each path registers its results: a valid strobe on the input produces a one-cycle valid pulse on the output one clock later. Between strobes, the result registers keep their last value.

A typical use puts the encode path on the write side of a small storage element or link and the check path on the read side. The error flag can be counted by surrounding logic.

Top module: `hcx_codec`

## Requirements
- R1: Codeword bit order, msb to lsb (`[6]` down to `[0]`), is d4 d3 d2 p4 d1 p2 p1. Nibble bit `[3]` is d4, `[2]` is d3, `[1]` is d2 and `[0]` is d1. The data positions of the codeword carry the input nibble unchanged.
- R2: With the sense input at 1 (even), the check bits are p4 = d2^d3^d4, p2 = d1^d3^d4 and p1 = d1^d2^d4.
- R3: With the sense input at 0 (odd), each check bit is the inverse of its even value.
- R4: The syndrome is three bits, with `[2]` = S3 = p4^d2^d3^d4, `[1]` = S2 = p2^d1^d3^d4 and `[0]` = S1 = p1^d1^d2^d4. In odd sense each syndrome bit is inverted. For a word with exactly one flipped bit, the syndrome equals that bit's position, counted 1..7 from the lsb.
- R5: A word with no error gives syndrome 000 and error flag 0, and the repaired word equals the received word.
- R6: The error flag is 1 exactly when the syndrome is nonzero. The repaired word is the received word with the bit at the syndrome position inverted. The recovered nibble is {repaired[6], repaired[5], repaired[4], repaired[2]}.
- R7: The outputs of a path are loaded on the clock edge that samples its input strobe, and that path's valid output is high for exactly the following cycle. With the strobe low, the result outputs hold their value.
- R8: A low level on the synchronous active-low reset clears every output of both paths to zero.
- R9: In even sense, the received word 0110111 gives syndrome 011, repaired word 0110011 and nibble 0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_valid_i | input | 1 | Strobe: encode the nibble this cycle |
| enc_data_i | input | 4 | Nibble to encode |
| enc_even_i | input | 1 | Parity sense for encoding, 1 even, 0 odd |
| enc_valid_o | output | 1 | Encoded word is new this cycle |
| enc_code_o | output | 7 | Encoded word |
| dec_valid_i | input | 1 | Strobe: check the word this cycle |
| dec_code_i | input | 7 | Received word |
| dec_even_i | input | 1 | Parity sense for checking, 1 even, 0 odd |
| dec_valid_o | output | 1 | Check results are new this cycle |
| dec_syndrome_o | output | 3 | Syndrome S3 S2 S1 |
| dec_err_o | output | 1 | Nonzero syndrome |
| dec_fixed_o | output | 7 | Repaired word |
| dec_data_o | output | 4 | Recovered nibble |

## Verification
The hardest case to reach from the ports is a single flip on each of the seven positions, including the three check-bit positions, in both parity senses. Only then does every syndrome value and every correction leg get exercised. The stimulus first encodes every nibble in each sense through the encode path. It then feeds that codeword back into the check path, once clean and once with each of the seven single-bit masks, and requires the syndrome to name the injected position and the nibble to come back intact. A reset applied while both strobes are high, and idle gaps after strobes, cover the clearing and holding behaviour.

// File: rtl/hcx_pkg.sv
package hcx_pkg;

    localparam int DATA_W = 4;
    localparam int PAR_W  = 3;
    localparam int CODE_W = DATA_W + PAR_W;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
    } enc_state_t;

    typedef struct packed {
        logic              vld;
        logic [PAR_W-1:0]  syn;
        logic              err;
        logic [CODE_W-1:0] fixed;
        logic [DATA_W-1:0] data;
    } dec_state_t;

    // position p (1-based) holds a check bit when p is a power of two
    function automatic bit is_par_pos(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // place nibble bits, lowest first, into the non-check positions
    function automatic logic [CODE_W-1:0] scatter(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] w;
        int k;
        w = '0;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_par_pos(p)) begin
                w[p-1] = d[k];
                k++;
            end
        end
        return w;
    endfunction

    // pull nibble bits back out of the non-check positions
    function automatic logic [DATA_W-1:0] gather(input logic [CODE_W-1:0] w);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_par_pos(p)) begin
                d[k] = w[p-1];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/hcx_enc_stage.sv
module hcx_enc_stage
    import hcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              even_i,
    output logic              vld_o,
    output logic [CODE_W-1:0] code_o
);

    enc_state_t st_d, st_q;

    always_comb begin
        logic [CODE_W-1:0] word;
        logic              par;
        st_d     = st_q;
        st_d.vld = vld_i;
        word     = scatter(data_i);
        for (int k = 0; k < PAR_W; k++) begin
            par = ~even_i;
            for (int p = 1; p <= CODE_W; p++) begin
                if ((((p >> k) & 1) == 1) && !is_par_pos(p)) begin
                    par = par ^ word[p-1];
                end
            end
            word[(1 << k) - 1] = par;
        end
        if (vld_i) begin
            st_d.code = word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign code_o = st_q.code;

    assert_enc_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o == $past(vld_i && rst_n));

    assert_enc_data_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> {code_o[6], code_o[5], code_o[4], code_o[2]} == $past(data_i));

    assert_enc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && $past(rst_n)) |=> $stable(code_o));

endmodule

// File: rtl/hcx_syn_calc.sv
module hcx_syn_calc
    import hcx_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              even_i,
    output logic [PAR_W-1:0]  syn_o
);

    for (genvar k = 0; k < PAR_W; k++) begin : g_syn
        logic acc;
        always_comb begin
            acc = ~even_i;
            for (int p = 1; p <= CODE_W; p++) begin
                if (((p >> k) & 1) == 1) begin
                    acc = acc ^ code_i[p-1];
                end
            end
        end
        assign syn_o[k] = acc;
    end

endmodule

// File: rtl/hcx_dec_stage.sv
module hcx_dec_stage
    import hcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              even_i,
    output logic              vld_o,
    output logic [PAR_W-1:0]  syn_o,
    output logic              err_o,
    output logic [CODE_W-1:0] fixed_o,
    output logic [DATA_W-1:0] data_o
);

    logic [PAR_W-1:0]  syn_now;
    logic [CODE_W-1:0] flip_mask;
    logic [CODE_W-1:0] repaired;
    dec_state_t        st_d, st_q;

    hcx_syn_calc i_syn (
        .code_i (code_i),
        .even_i (even_i),
        .syn_o  (syn_now)
    );

    for (genvar i = 0; i < CODE_W; i++) begin : g_flip
        assign flip_mask[i] = (syn_now == PAR_W'(i + 1));
    end

    assign repaired = code_i ^ flip_mask;

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.syn   = syn_now;
            st_d.err   = |syn_now;
            st_d.fixed = repaired;
            st_d.data  = gather(repaired);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o   = st_q.vld;
    assign syn_o   = st_q.syn;
    assign err_o   = st_q.err;
    assign fixed_o = st_q.fixed;
    assign data_o  = st_q.data;

    assert_dec_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o == $past(vld_i && rst_n));

    assert_clean_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !err_o) |-> fixed_o == $past(code_i));

    assert_single_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && err_o) |-> $countones(fixed_o ^ $past(code_i)) == 1);

    assert_dec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && $past(rst_n)) |=> ($stable(syn_o) && $stable(fixed_o)));

endmodule

// File: rtl/hcx_codec.sv
module hcx_codec
    import hcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    input  logic              enc_even_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    input  logic              dec_even_i,
    output logic              dec_valid_o,
    output logic [PAR_W-1:0]  dec_syndrome_o,
    output logic              dec_err_o,
    output logic [CODE_W-1:0] dec_fixed_o,
    output logic [DATA_W-1:0] dec_data_o
);

    hcx_enc_stage i_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (enc_valid_i),
        .data_i (enc_data_i),
        .even_i (enc_even_i),
        .vld_o  (enc_valid_o),
        .code_o (enc_code_o)
    );

    hcx_dec_stage i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (dec_valid_i),
        .code_i  (dec_code_i),
        .even_i  (dec_even_i),
        .vld_o   (dec_valid_o),
        .syn_o   (dec_syndrome_o),
        .err_o   (dec_err_o),
        .fixed_o (dec_fixed_o),
        .data_o  (dec_data_o)
    );

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!enc_valid_o && enc_code_o == '0 && !dec_valid_o &&
                    dec_syndrome_o == '0 && !dec_err_o && dec_fixed_o == '0 &&
                    dec_data_o == '0));

endmodule

// File: tb/test_hcx_codec.sv
module test_hcx_codec;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_valid_i = 1'b0;
    logic [3:0] enc_data_i = '0;
    logic       enc_even_i = 1'b1;
    logic       enc_valid_o;
    logic [6:0] enc_code_o;
    logic       dec_valid_i = 1'b0;
    logic [6:0] dec_code_i = '0;
    logic       dec_even_i = 1'b1;
    logic       dec_valid_o;
    logic [2:0] dec_syndrome_o;
    logic       dec_err_o;
    logic [6:0] dec_fixed_o;
    logic [3:0] dec_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit cmp_en = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hcx_codec i_hcx_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i), .enc_even_i(enc_even_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i), .dec_even_i(dec_even_i),
        .dec_valid_o(dec_valid_o), .dec_syndrome_o(dec_syndrome_o), .dec_err_o(dec_err_o),
        .dec_fixed_o(dec_fixed_o), .dec_data_o(dec_data_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_encode(input logic [3:0] d, input logic ev);
        logic p4, p2, p1;
        p4 = d[1] ^ d[2] ^ d[3];
        p2 = d[0] ^ d[2] ^ d[3];
        p1 = d[0] ^ d[1] ^ d[3];
        if (!ev) begin
            p4 = ~p4; p2 = ~p2; p1 = ~p1;
        end
        return {d[3], d[2], d[1], p4, d[0], p2, p1};
    endfunction

    function automatic logic [2:0] ref_syn(input logic [6:0] c, input logic ev);
        logic [2:0] s;
        s[2] = c[3] ^ c[4] ^ c[5] ^ c[6];
        s[1] = c[1] ^ c[2] ^ c[5] ^ c[6];
        s[0] = c[0] ^ c[2] ^ c[4] ^ c[6];
        if (!ev) s = ~s;
        return s;
    endfunction

    // behavioural reference, one register stage
    logic       m_ev, m_dv, m_err;
    logic [6:0] m_code, m_fixed;
    logic [2:0] m_syn;
    logic [3:0] m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ev = 0; m_code = 0; m_dv = 0; m_syn = 0; m_err = 0; m_fixed = 0; m_data = 0;
        end else begin
            m_ev = enc_valid_i;
            if (enc_valid_i) m_code = ref_encode(enc_data_i, enc_even_i);
            m_dv = dec_valid_i;
            if (dec_valid_i) begin
                m_syn   = ref_syn(dec_code_i, dec_even_i);
                m_err   = (m_syn != 0);
                m_fixed = dec_code_i;
                if (m_syn != 0) m_fixed[int'(m_syn) - 1] = ~m_fixed[int'(m_syn) - 1];
                m_data  = {m_fixed[6], m_fixed[5], m_fixed[4], m_fixed[2]};
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check(enc_valid_o == m_ev, "R7 model enc valid", int'(enc_valid_o), int'(m_ev));
            check(enc_code_o == m_code, "R2 model enc code", int'(enc_code_o), int'(m_code));
            check(dec_valid_o == m_dv, "R7 model dec valid", int'(dec_valid_o), int'(m_dv));
            check(dec_syndrome_o == m_syn, "R4 model syndrome", int'(dec_syndrome_o), int'(m_syn));
            check(dec_err_o == m_err, "R6 model err", int'(dec_err_o), int'(m_err));
            check(dec_fixed_o == m_fixed, "R6 model fixed", int'(dec_fixed_o), int'(m_fixed));
            check(dec_data_o == m_data, "R6 model data", int'(dec_data_o), int'(m_data));
        end
    end

    task automatic check_cleared(input string tag);
        check({enc_valid_o, enc_code_o, dec_valid_o, dec_syndrome_o, dec_err_o,
               dec_fixed_o, dec_data_o} == '0, tag,
              int'({enc_code_o, dec_fixed_o}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [6:0] code;
        logic [6:0] held;
        repeat (3) @(negedge clk);
        check_cleared("R8 reset state");
        rst_n = 1'b1;
        cmp_en = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 16; d++) begin
                @(negedge clk);
                enc_valid_i = 1'b1; enc_data_i = 4'(d); enc_even_i = m[0];
                @(negedge clk);
                enc_valid_i = 1'b0;
                code = enc_code_o;
                check(enc_valid_o == 1'b1, "R7 enc strobe", int'(enc_valid_o), 1);
                check(code == ref_encode(4'(d), m[0]), m == 1 ? "R2 even encode" : "R3 odd encode",
                      int'(code), int'(ref_encode(4'(d), m[0])));
                check({code[6], code[5], code[4], code[2]} == 4'(d), "R1 layout",
                      int'({code[6], code[5], code[4], code[2]}), d);
                for (int e = 0; e < 8; e++) begin
                    dec_valid_i = 1'b1;
                    dec_even_i  = m[0];
                    dec_code_i  = (e == 0) ? code : (code ^ (7'd1 << (e - 1)));
                    @(negedge clk);
                    dec_valid_i = 1'b0;
                    check(dec_syndrome_o == 3'(e), "R4 syndrome position", int'(dec_syndrome_o), e);
                    check(dec_data_o == 4'(d), "R6 data recovered", int'(dec_data_o), d);
                    check(dec_fixed_o == code, "R6 word repaired", int'(dec_fixed_o), int'(code));
                    check(dec_err_o == (e != 0), e == 0 ? "R5 clean flag" : "R6 err flag",
                          int'(dec_err_o), int'(e != 0));
                end
            end
        end

        // fixed vector
        @(negedge clk);
        dec_valid_i = 1'b1; dec_even_i = 1'b1; dec_code_i = 7'b0110111;
        @(negedge clk);
        dec_valid_i = 1'b0;
        check(dec_syndrome_o == 3'b011, "R9 vector syndrome", int'(dec_syndrome_o), 3);
        check(dec_fixed_o == 7'b0110011, "R9 vector word", int'(dec_fixed_o), 7'h33);
        check(dec_data_o == 4'b0110, "R9 vector data", int'(dec_data_o), 6);

        // hold with strobe low
        held = dec_fixed_o;
        dec_code_i = 7'b1010101;
        repeat (3) @(negedge clk);
        check(dec_fixed_o == held && dec_valid_o == 1'b0, "R7 hold", int'(dec_fixed_o), int'(held));

        // reset while both strobes are high
        enc_valid_i = 1'b1; enc_data_i = 4'hF;
        dec_valid_i = 1'b1; dec_code_i = 7'b1111110;
        rst_n = 1'b0;
        @(negedge clk);
        check_cleared("R8 reset mid run");
        enc_valid_i = 1'b0; dec_valid_i = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule